// File: doc/BRIEF.md
# PHY Register Access Command Engine

This block lets a host processor run one PHY management transaction at a time through a few memory-mapped words. The host stores a target port (or a port bitmap), write data, an MMD device and address, and then writes a control word that chooses between a paged read, a paged write, an MMD read and an MMD write, and sets an execute bit. The engine checks the target port, latches the command and presents it on a PHY-side request port. It holds the request until a response arrives, or until a cycle limit expires. Then it clears execute and records read data or a failure flag for the host to poll.

The host side is a plain word-addressed register port with a write strobe and a read bus that responds in the same cycle. The PHY side is a level request with a one-cycle acknowledge that carries read data and an error indication. MDIO serial timing lies outside the block.

Top module: `phyacc_engine`

## Requirements
- R1: After reset every host-visible word (offsets 0 to 4) reads zero and no PHY request is raised.
- R2: Writing the control word (offset 0) with bit 0 set starts a transaction. Bit 0 reads 1 while the transaction is in flight and reads 0 once it has completed.
- R3: Control bit 3 set requests a write and clear requests a read. Control bit 2 set requests MMD access. The PHY request carries both choices.
- R4: The register number is taken from control bits 9:5 and the page from bits 22:10. Both are forwarded with a paged request and both read back at the same positions.
- R5: Control bits 27:23 read 0x1F when the stored page equals 0x1FFF and read zero for any other page.
- R6: For a read, bits 31:16 of the data word (offset 1) give the target port. On completion the returned value appears in data-word bits 15:0.
- R7: For a write, data-word bits 31:16 are the write data. The target is the lowest set bit of a 64-bit port bitmap, whose bits 31:0 are at offset 2 and bits 63:32 at offset 3.
- R8: The MMD word (offset 4) carries the device number in bits 31:16 and the register address in bits 15:0. Both are forwarded with an MMD request.
- R9: After a paged operation, control bit 1 equals the PHY error indication. For MMD operations the PHY error is ignored and bit 1 reads 0.
- R10: A target port at or above CPU_PORT, or an empty bitmap for a write, starts no request. Bit 0 stays 0 and bit 1 reads 1.
- R11: While bit 0 is set, host writes to the control word are ignored. They change neither the fields read back nor the request in flight.
- R12: If no acknowledge arrives, bit 0 clears after exactly TMO_CYC cycles, bit 1 reads 1 and the request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| phy_req | output | 1 | PHY request, held until acknowledge or timeout |
| phy_we | output | 1 | Request is a write |
| phy_mmd | output | 1 | Request is MMD access |
| phy_port | output | 6 | Target port number |
| phy_page | output | 13 | Page for paged access |
| phy_reg | output | 5 | Register for paged access |
| phy_dev | output | 16 | MMD device number |
| phy_maddr | output | 16 | MMD register address |
| phy_wdata | output | 16 | Write data |
| phy_ack | input | 1 | One-cycle response strobe |
| phy_err | input | 1 | Response error indication |
| phy_rdata | input | 16 | Response read data |

## Verification
The bench aims at the ports nearest the CPU_PORT limit. Port 51 must pass, while ports 52, 60 and 256 must raise no request. A comparison that was off by one, or that truncated the port field, would start a transaction that should never happen. A write targeted through the high half of the bitmap shows whether the two words are joined in the right order. A second control write during a long transaction shows whether the latched command can be overwritten. An MMD write that returns an error shows whether the failure flag wrongly follows the PHY. Muting the PHY and counting the busy cycles exposes a timeout that fires one cycle early or late.

// File: rtl/phyacc_pkg.sv
package phyacc_pkg;
   localparam int PAGE_W = 13;
   localparam int REG_W  = 5;
   localparam int DW     = 16;

   localparam logic [2:0] OFS_ACC  = 3'd0;
   localparam logic [2:0] OFS_DATA = 3'd1;
   localparam logic [2:0] OFS_MLO  = 3'd2;
   localparam logic [2:0] OFS_MHI  = 3'd3;
   localparam logic [2:0] OFS_MMD  = 3'd4;

   localparam int B_EXEC   = 0;
   localparam int B_FAIL   = 1;
   localparam int B_MMD    = 2;
   localparam int B_WR     = 3;
   localparam int REG_LSB  = 5;
   localparam int PAGE_LSB = 10;
   localparam int RAW_LSB  = 23;

   localparam logic [PAGE_W-1:0] RAW_PAGE = '1;

   typedef struct packed {
      logic              we;
      logic              mmd;
      logic [REG_W-1:0]  regn;
      logic [PAGE_W-1:0] page;
   } cmd_t;

   function automatic cmd_t decode_acc(input logic [31:0] w);
      cmd_t c;
      c.we   = w[B_WR];
      c.mmd  = w[B_MMD];
      c.regn = w[REG_LSB +: REG_W];
      c.page = w[PAGE_LSB +: PAGE_W];
      return c;
   endfunction
endpackage

// File: rtl/phyacc_portsel.sv
module phyacc_portsel #(
   parameter int NPORT  = 64,
   parameter int PORT_W = 6
) (
   input  logic [NPORT-1:0]  mask,
   output logic [PORT_W-1:0] idx,
   output logic              any
);
   always_comb begin
      idx = '0;
      for (int i = NPORT - 1; i >= 0; i--) begin
         if (mask[i]) idx = PORT_W'(i);
      end
   end
   assign any = |mask;
endmodule

// File: rtl/phyacc_csr.sv
module phyacc_csr
   import phyacc_pkg::*;
#(
   parameter int NPORT = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_we,
   input  logic [2:0]       host_addr,
   input  logic [31:0]      host_wdata,
   input  logic             busy,
   input  logic             cpl_rd,
   input  logic [DW-1:0]    cpl_data,
   output cmd_t             cmd_q,
   output logic [DW-1:0]    data_hi_q,
   output logic [DW-1:0]    rd_res_q,
   output logic [NPORT-1:0] mask,
   output logic [31:0]      mask_lo_rd,
   output logic [31:0]      mask_hi_rd,
   output logic [DW-1:0]    dev_q,
   output logic [DW-1:0]    maddr_q,
   output logic             acc_wr_ok
);
   localparam int LO_W = (NPORT > 32) ? 32 : NPORT;

   logic [LO_W-1:0] lo_q;

   assign acc_wr_ok  = host_we && (host_addr == OFS_ACC) && !busy;
   assign mask_lo_rd = 32'(lo_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         data_hi_q <= '0;
         rd_res_q  <= '0;
         lo_q      <= '0;
         dev_q     <= '0;
         maddr_q   <= '0;
      end else begin
         if (acc_wr_ok) cmd_q <= decode_acc(host_wdata);
         if (host_we && host_addr == OFS_DATA) data_hi_q <= host_wdata[31:16];
         if (host_we && host_addr == OFS_MLO)  lo_q <= host_wdata[LO_W-1:0];
         if (host_we && host_addr == OFS_MMD) begin
            dev_q   <= host_wdata[31:16];
            maddr_q <= host_wdata[15:0];
         end
         if (cpl_rd) rd_res_q <= cpl_data;
      end
   end

   generate
      if (NPORT > 32) begin : g_hi
         logic [NPORT-33:0] hi_q;
         always_ff @(posedge clk) begin
            if (!rst_n) hi_q <= '0;
            else if (host_we && host_addr == OFS_MHI) hi_q <= host_wdata[NPORT-33:0];
         end
         assign mask       = {hi_q, lo_q};
         assign mask_hi_rd = 32'(hi_q);
      end else begin : g_nohi
         assign mask       = lo_q;
         assign mask_hi_rd = '0;
      end
   endgenerate
endmodule

// File: rtl/phyacc_seq.sv
module phyacc_seq
   import phyacc_pkg::*;
#(
   parameter int PORT_W = 6,
   parameter int TMO    = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              port_ok,
   input  cmd_t              cmd,
   input  logic [PORT_W-1:0] port,
   input  logic [DW-1:0]     wdata,
   input  logic [DW-1:0]     dev,
   input  logic [DW-1:0]     maddr,
   input  logic              phy_ack,
   input  logic              phy_err,
   output logic              busy,
   output logic              fail,
   output cmd_t              req_cmd,
   output logic [PORT_W-1:0] req_port,
   output logic [DW-1:0]     req_wdata,
   output logic [DW-1:0]     req_dev,
   output logic [DW-1:0]     req_maddr,
   output logic              cpl_rd
);
   localparam int TW = $clog2(TMO + 1);

   logic [TW-1:0] cnt_q;

   assign cpl_rd = busy && phy_ack && !req_cmd.we;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         fail      <= 1'b0;
         cnt_q     <= '0;
         req_cmd   <= '0;
         req_port  <= '0;
         req_wdata <= '0;
         req_dev   <= '0;
         req_maddr <= '0;
      end else if (!busy) begin
         if (start && port_ok) begin
            busy      <= 1'b1;
            fail      <= 1'b0;
            cnt_q     <= '0;
            req_cmd   <= cmd;
            req_port  <= port;
            req_wdata <= wdata;
            req_dev   <= dev;
            req_maddr <= maddr;
         end else if (start) begin
            fail <= 1'b1;
         end
      end else if (phy_ack) begin
         busy <= 1'b0;
         fail <= phy_err && !req_cmd.mmd;
      end else if (cnt_q == TW'(TMO - 1)) begin
         busy <= 1'b0;
         fail <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/phyacc_engine.sv
module phyacc_engine
   import phyacc_pkg::*;
#(
   parameter int NPORT    = 64,
   parameter int CPU_PORT = 52,
   parameter int TMO_CYC  = 64,
   localparam int PORT_W  = $clog2(NPORT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [2:0]        host_addr,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   output logic              phy_req,
   output logic              phy_we,
   output logic              phy_mmd,
   output logic [PORT_W-1:0] phy_port,
   output logic [12:0]       phy_page,
   output logic [4:0]        phy_reg,
   output logic [15:0]       phy_dev,
   output logic [15:0]       phy_maddr,
   output logic [15:0]       phy_wdata,
   input  logic              phy_ack,
   input  logic              phy_err,
   input  logic [15:0]       phy_rdata
);
   generate
      if (NPORT < 2 || NPORT > 64) begin : g_bad_nport
         $error("NPORT must lie in 2..64");
      end
      if (CPU_PORT < 1 || CPU_PORT > NPORT) begin : g_bad_cpu
         $error("CPU_PORT must lie in 1..NPORT");
      end
      if (TMO_CYC < 2) begin : g_bad_tmo
         $error("TMO_CYC must be at least 2");
      end
   endgenerate

   cmd_t              cmd_q, req_cmd, cmd_new;
   logic [DW-1:0]     data_hi_q, rd_res_q, dev_q, maddr_q;
   logic [NPORT-1:0]  mask;
   logic [31:0]       mask_lo_rd, mask_hi_rd;
   logic              acc_wr_ok, start, port_ok, exec_w, fail_w, cpl_rd;
   logic [PORT_W-1:0] sel_idx, tgt_port;
   logic              mask_any;

   assign cmd_new = decode_acc(host_wdata);
   assign start   = acc_wr_ok && host_wdata[B_EXEC];

   phyacc_csr #(.NPORT(NPORT)) u_csr (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .busy(exec_w), .cpl_rd(cpl_rd), .cpl_data(phy_rdata),
      .cmd_q(cmd_q), .data_hi_q(data_hi_q), .rd_res_q(rd_res_q), .mask(mask),
      .mask_lo_rd(mask_lo_rd), .mask_hi_rd(mask_hi_rd), .dev_q(dev_q),
      .maddr_q(maddr_q), .acc_wr_ok(acc_wr_ok)
   );

   phyacc_portsel #(.NPORT(NPORT), .PORT_W(PORT_W)) u_sel (
      .mask(mask), .idx(sel_idx), .any(mask_any)
   );

   always_comb begin
      if (cmd_new.we) begin
         tgt_port = sel_idx;
         port_ok  = mask_any && ((PORT_W+1)'(sel_idx) < (PORT_W+1)'(CPU_PORT));
      end else begin
         tgt_port = data_hi_q[PORT_W-1:0];
         port_ok  = data_hi_q < DW'(CPU_PORT);
      end
   end

   phyacc_seq #(.PORT_W(PORT_W), .TMO(TMO_CYC)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .port_ok(port_ok), .cmd(cmd_new),
      .port(tgt_port), .wdata(data_hi_q), .dev(dev_q), .maddr(maddr_q),
      .phy_ack(phy_ack), .phy_err(phy_err), .busy(exec_w), .fail(fail_w),
      .req_cmd(req_cmd), .req_port(phy_port), .req_wdata(phy_wdata),
      .req_dev(phy_dev), .req_maddr(phy_maddr), .cpl_rd(cpl_rd)
   );

   assign phy_req  = exec_w;
   assign phy_we   = req_cmd.we;
   assign phy_mmd  = req_cmd.mmd;
   assign phy_page = req_cmd.page;
   assign phy_reg  = req_cmd.regn;

   always_comb begin
      host_rdata = '0;
      case (host_addr)
         OFS_ACC: begin
            host_rdata[B_EXEC]               = exec_w;
            host_rdata[B_FAIL]               = fail_w;
            host_rdata[B_MMD]                = cmd_q.mmd;
            host_rdata[B_WR]                 = cmd_q.we;
            host_rdata[REG_LSB +: REG_W]     = cmd_q.regn;
            host_rdata[PAGE_LSB +: PAGE_W]   = cmd_q.page;
            host_rdata[RAW_LSB +: 5]         = (cmd_q.page == RAW_PAGE) ? 5'h1f : 5'h00;
         end
         OFS_DATA: host_rdata = {data_hi_q, rd_res_q};
         OFS_MLO:  host_rdata = mask_lo_rd;
         OFS_MHI:  host_rdata = mask_hi_rd;
         OFS_MMD:  host_rdata = {dev_q, maddr_q};
         default:  host_rdata = '0;
      endcase
   end
endmodule

// File: rtl/phyacc_engine_chk.sv
module phyacc_engine_chk #(
   parameter int NPORT    = 64,
   parameter int CPU_PORT = 52,
   parameter int TMO      = 64,
   localparam int PORT_W  = $clog2(NPORT),
   localparam int TW      = $clog2(TMO + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              phy_ack,
   input logic              phy_we,
   input logic [PORT_W-1:0] phy_port,
   input logic [12:0]       phy_page,
   input logic [4:0]        phy_reg,
   input logic [2:0]        host_addr,
   input logic [31:0]       host_rdata
);
   logic [TW:0] wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) wait_q <= '0;
      else                 wait_q <= wait_q + 1'b1;
   end

   assert_ack_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && phy_ack) |=> !busy);

   assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(phy_port) && $stable(phy_we) && $stable(phy_reg) && $stable(phy_page)));

   assert_port_below_cpu_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ((PORT_W+1)'(phy_port) < (PORT_W+1)'(CPU_PORT)));

   assert_raw_field_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_addr == 3'd0) |->
         (host_rdata[27:23] == ((host_rdata[22:10] == 13'h1fff) ? 5'h1f : 5'h00)));

   assert_timeout_bound_R12: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (wait_q < (TW+1)'(TMO)));
endmodule

bind phyacc_engine phyacc_engine_chk #(.NPORT(NPORT), .CPU_PORT(CPU_PORT), .TMO(TMO_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(exec_w), .phy_ack(phy_ack), .phy_we(phy_we),
   .phy_port(phy_port), .phy_page(phy_page), .phy_reg(phy_reg),
   .host_addr(host_addr), .host_rdata(host_rdata)
);

// File: tb/phyacc_engine_test.sv
`timescale 1ns/1ps
module phyacc_engine_test;
   localparam int TMO = 20;

   typedef struct packed {
      logic        we;
      logic        mmd;
      logic [5:0]  port;
      logic [12:0] page;
      logic [4:0]  regn;
      logic [15:0] dev;
      logic [15:0] maddr;
      logic [15:0] wdata;
      logic        err;
      logic [3:0]  dly;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b0, 1'b0, 6'd3,  13'h0000, 5'd2,  16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd1},
      '{1'b1, 1'b0, 6'd5,  13'h1fff, 5'd31, 16'h0000, 16'h0000, 16'ha5a5, 1'b0, 4'd3},
      '{1'b1, 1'b0, 6'd40, 13'h0100, 5'd9,  16'h0000, 16'h0000, 16'h1234, 1'b1, 4'd2},
      '{1'b0, 1'b0, 6'd51, 13'h1fff, 5'd0,  16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd4},
      '{1'b0, 1'b1, 6'd7,  13'h0000, 5'd0,  16'h001e, 16'hc0de, 16'h0000, 1'b0, 4'd2},
      '{1'b1, 1'b1, 6'd33, 13'h0000, 5'd0,  16'h0007, 16'h003c, 16'hbeef, 1'b1, 4'd5},
      '{1'b0, 1'b1, 6'd0,  13'h0000, 5'd0,  16'h001f, 16'hffff, 16'h0000, 1'b1, 4'd0},
      '{1'b1, 1'b0, 6'd0,  13'h1ffe, 5'd16, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        h_we = 1'b0;
   logic [2:0]  h_addr = 3'd0;
   logic [31:0] h_wd = '0;
   logic [31:0] h_rd;
   logic        phy_req, phy_we, phy_mmd;
   logic [5:0]  phy_port;
   logic [12:0] phy_page;
   logic [4:0]  phy_reg;
   logic [15:0] phy_dev, phy_maddr, phy_wdata;
   logic        phy_ack = 1'b0;
   logic        phy_err = 1'b0;
   logic [15:0] phy_rdata = '0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   phyacc_engine #(.NPORT(64), .CPU_PORT(52), .TMO_CYC(TMO)) uut (
      .clk(clk), .rst_n(rst_n), .host_we(h_we), .host_addr(h_addr),
      .host_wdata(h_wd), .host_rdata(h_rd), .phy_req(phy_req), .phy_we(phy_we),
      .phy_mmd(phy_mmd), .phy_port(phy_port), .phy_page(phy_page), .phy_reg(phy_reg),
      .phy_dev(phy_dev), .phy_maddr(phy_maddr), .phy_wdata(phy_wdata),
      .phy_ack(phy_ack), .phy_err(phy_err), .phy_rdata(phy_rdata)
   );

   // PHY responder model
   bit          mute = 0;
   bit          err_set = 0;
   int          dly_set = 0;
   int          wait_n = 0;
   int          rises = 0;
   bit          prev_req = 0;
   logic        cap_we, cap_mmd;
   logic [5:0]  cap_port;
   logic [12:0] cap_page;
   logic [4:0]  cap_reg;
   logic [15:0] cap_dev, cap_maddr, cap_wdata;

   function automatic logic [15:0] model_rd(input logic mmd, input logic [5:0] port,
         input logic [12:0] page, input logic [4:0] regn,
         input logic [15:0] dev, input logic [15:0] maddr);
      if (mmd) return dev ^ {maddr[7:0], maddr[15:8]} ^ {10'd0, port};
      return {port, regn, 5'd0} ^ {3'd0, page};
   endfunction

   always @(negedge clk) begin
      if (phy_req && !prev_req) rises++;
      prev_req = phy_req;
      if (phy_ack) begin
         phy_ack = 1'b0;
      end else if (!phy_req) begin
         wait_n = 0;
      end else if (!mute) begin
         if (wait_n >= dly_set) begin
            phy_ack   = 1'b1;
            phy_err   = err_set;
            phy_rdata = model_rd(phy_mmd, phy_port, phy_page, phy_reg, phy_dev, phy_maddr);
            cap_we = phy_we; cap_mmd = phy_mmd; cap_port = phy_port; cap_page = phy_page;
            cap_reg = phy_reg; cap_dev = phy_dev; cap_maddr = phy_maddr; cap_wdata = phy_wdata;
            wait_n = 0;
         end else begin
            wait_n++;
         end
      end
   end

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", what, act, exp);
      end
   endtask

   task automatic host_write(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      h_we = 1'b1; h_addr = a; h_wd = d;
      @(negedge clk);
      h_we = 1'b0;
   endtask

   task automatic host_read(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      h_addr = a;
      #1 d = h_rd;
   endtask

   function automatic logic [31:0] acc_word(input logic we, input logic mmd,
         input logic [4:0] regn, input logic [12:0] page, input logic ex);
      return (32'(page) << 10) | (32'(regn) << 5) | (32'(we) << 3) | (32'(mmd) << 2) | 32'(ex);
   endfunction

   task automatic wait_idle(output logic [31:0] r);
      int n = 0;
      do begin host_read(3'd0, r); n++; end while (r[0] && n < 300);
   endtask

   task automatic run_op(input vec_t v, input int k);
      logic [31:0] r;
      logic [63:0] m;
      err_set = v.err;
      dly_set = int'(v.dly);
      host_write(3'd4, {v.dev, v.maddr});
      if (v.we) begin
         m = 64'd1 << v.port;
         host_write(3'd2, m[31:0]);
         host_write(3'd3, m[63:32]);
         host_write(3'd1, {v.wdata, 16'h0});
      end else begin
         host_write(3'd1, {10'd0, v.port, 16'h0});
      end
      host_write(3'd0, acc_word(v.we, v.mmd, v.regn, v.page, 1'b1));
      if (v.dly >= 3) begin
         host_read(3'd0, r);
         chk({31'd0, r[0]}, 32'd1, $sformatf("R2 exec high in flight vec %0d", k));
      end
      wait_idle(r);
      chk({31'd0, r[0]}, 32'd0, $sformatf("R2 exec clears vec %0d", k));
      chk({31'd0, r[1]}, {31'd0, v.err & ~v.mmd}, $sformatf("R9 fail flag vec %0d", k));
      chk({30'd0, cap_we, cap_mmd}, {30'd0, v.we, v.mmd}, $sformatf("R3 kind vec %0d", k));
      chk({26'd0, cap_port}, {26'd0, v.port}, $sformatf("R6/R7 port vec %0d", k));
      if (v.mmd) begin
         chk({cap_dev, cap_maddr}, {v.dev, v.maddr}, $sformatf("R8 mmd fields vec %0d", k));
      end else begin
         chk({14'd0, cap_page, cap_reg}, {14'd0, v.page, v.regn}, $sformatf("R4 page/reg vec %0d", k));
         chk(32'(r[27:23]), (v.page == 13'h1fff) ? 32'h1f : 32'h0, $sformatf("R5 raw field vec %0d", k));
      end
      if (v.we) begin
         chk({16'd0, cap_wdata}, {16'd0, v.wdata}, $sformatf("R7 write data vec %0d", k));
      end else begin
         host_read(3'd1, r);
         chk({16'd0, r[15:0]}, {16'd0, model_rd(v.mmd, v.port, v.page, v.regn, v.dev, v.maddr)},
             $sformatf("R6 read result vec %0d", k));
      end
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      int n, base;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         host_read(3'(a), r);
         chk(r, 32'd0, $sformatf("R1 reset word %0d", a));
      end
      chk({31'd0, phy_req}, 32'd0, "R1 no request after reset");

      // table-driven transactions
      for (int i = 0; i < 8; i++) run_op(VEC[i], i);

      // R5 raw field without execute
      host_write(3'd0, acc_word(1'b0, 1'b0, 5'd1, 13'h1fff, 1'b0));
      host_read(3'd0, r);
      chk(32'(r[27:23]), 32'h1f, "R5 raw field for page 0x1fff");
      chk({31'd0, r[0]}, 32'd0, "R2 no start without exec");
      host_write(3'd0, acc_word(1'b0, 1'b0, 5'd1, 13'h1ffe, 1'b0));
      host_read(3'd0, r);
      chk(32'(r[27:23]), 32'h0, "R5 raw field zero for page 0x1ffe");

      // R11 control writes ignored while busy
      base = rises;
      dly_set = 8; err_set = 0;
      host_write(3'd1, {16'd2, 16'h0});
      host_write(3'd0, acc_word(1'b0, 1'b0, 5'd4, 13'd3, 1'b1));
      host_write(3'd0, acc_word(1'b1, 1'b1, 5'd9, 13'd5, 1'b1));
      host_read(3'd0, r);
      chk({27'd0, r[9:5]}, 32'd4, "R11 reg field kept while busy");
      chk({19'd0, r[22:10]}, 32'd3, "R11 page field kept while busy");
      chk({28'd0, r[3:2], 1'b0, r[0]}, 32'd1, "R11 kind kept, exec high");
      wait_idle(r);
      chk({27'd0, cap_reg}, 32'd4, "R11 request reg unchanged");
      chk({31'd0, cap_we}, 32'd0, "R11 request stays read");
      chk(32'(rises - base), 32'd1, "R11 single request");

      // R10 rejected ports
      base = rises;
      host_write(3'd1, {16'd52, 16'h0});
      host_write(3'd0, acc_word(1'b0, 1'b0, 5'd0, 13'd0, 1'b1));
      host_read(3'd0, r);
      chk({30'd0, r[1:0]}, 32'd2, "R10 read port 52 rejected");
      host_write(3'd1, {16'h0100, 16'h0});
      host_write(3'd0, acc_word(1'b0, 1'b0, 5'd0, 13'd0, 1'b1));
      host_read(3'd0, r);
      chk({30'd0, r[1:0]}, 32'd2, "R10 read port 256 rejected");
      host_write(3'd2, 32'd0);
      host_write(3'd3, 32'h1000_0000);
      host_write(3'd0, acc_word(1'b1, 1'b0, 5'd0, 13'd0, 1'b1));
      host_read(3'd0, r);
      chk({30'd0, r[1:0]}, 32'd2, "R10 write mask port 60 rejected");
      host_write(3'd3, 32'd0);
      host_write(3'd0, acc_word(1'b1, 1'b1, 5'd0, 13'd0, 1'b1));
      host_read(3'd0, r);
      chk({30'd0, r[1:0]}, 32'd2, "R10 empty mask rejected");
      chk(32'(rises - base), 32'd0, "R10 no request raised");

      // R12 timeout
      mute = 1;
      host_write(3'd1, {16'd1, 16'h0});
      host_write(3'd0, acc_word(1'b0, 1'b0, 5'd0, 13'd0, 1'b1));
      n = 0;
      #1;
      while (h_rd[0] && n < 1000) begin
         n++;
         @(negedge clk);
         #1;
      end
      chk(32'(n), 32'(TMO), "R12 busy cycles before timeout");
      chk({30'd0, h_rd[1:0]}, 32'd2, "R12 fail set, exec clear");
      chk({31'd0, phy_req}, 32'd0, "R12 request withdrawn");
      mute = 0;

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule